// File: doc/BRIEF.md
# Flash Read Accelerator with Sequential Prefetch

This block sits between a 32-bit processor read port and a flash array that delivers one 128-bit line per access after a programmable number of wait states. The flash is organised as lines of four 32-bit words aligned on 16-byte boundaries. Instruction fetches are served from a pair of line buffers that take turns. While the processor reads from one buffer, the next sequential line is fetched into the other. Once a sequential run has started, every later fetch in it completes in a single cycle.

Data reads use a third line buffer of their own, which always holds the most recently missed data line. Any later data read whose address falls in that line is returned in one cycle, in any order and with any other reads in between. Only one flash line access is in flight at a time. A code miss that jumps away from the sequential stream cancels an outstanding code prefetch. A data miss waits for the running access to finish.

Top module: `flash_read_accel`

## Requirements
- R1: A response carries word k of the line at address bits [31:4], where k is address bits [3:2]. The flash line index is driven on `fl_addr`, and word k occupies bits [32k+31:32k] of `fl_rdata`.
- R2: A code or data miss that finds the flash idle answers after exactly FWS+1 cycles, counting the request cycle as the first. During those cycles `fl_req` stays high with a stable `fl_addr`.
- R3: A code read whose line is held in either prefetch buffer answers in the same cycle it is presented.
- R4: When a code read hits a buffered line while the flash is idle, the fetch of the following line (line index plus one) starts at once into the other code buffer, unless that buffer already holds it. For every FWS from 0 to 3, each read of a sequential word stream after its first answers in one cycle.
- R5: A data miss loads the whole aligned line into the data buffer. Later data reads anywhere in that line answer in one cycle and start no flash access, whatever their order.
- R6: Only one flash access runs at a time. A data miss that arrives during another access waits for it to finish and then takes its own FWS+1 cycles.
- R7: A code miss that arrives while a code prefetch of a different line is still running cancels that prefetch. The miss answers FWS+1 cycles after it is presented.
- R8: A code refill goes into the code buffer that was not read most recently, so the line read last stays a hit. The two code buffers never hold the same line.
- R9: Synchronous reset and the `flush` input both invalidate all three buffers, so the next read of any earlier line is a miss.
- R10: `rsp_ready` is high for exactly one cycle per request, together with the read data, and never while `req_valid` is low.
- R11: With FWS=0, a miss answers in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all line buffers |
| fws | input | 2 | Flash wait states (0 to 3) |
| req_valid | input | 1 | Read request present |
| req_is_data | input | 1 | 1 = data read, 0 = code fetch |
| req_addr | input | 32 | Byte address of the requested word |
| rsp_ready | output | 1 | Read completes this cycle |
| rsp_rdata | output | 32 | Read data, valid with `rsp_ready` |
| fl_req | output | 1 | Flash line access in progress |
| fl_addr | output | 28 | Flash line index (address bits [31:4]) |
| fl_rdata | input | 128 | Line returned by the flash |

## Verification
The assertions and the results rely on three conditions on the inputs:
- `fws` does not change while a flash access is in flight.
- The requester holds `req_valid`, `req_is_data` and `req_addr` steady until `rsp_ready`.
- The flash returns a correct line once `fl_addr` has been held for FWS+1 cycles.

The stimulus changes `fws` only after several idle cycles, and every request is held until it completes. The flash model returns a poison pattern whenever the address has been stable for fewer cycles than FWS+1. Because of that model, a design that samples the line too early shows up as a data mismatch rather than passing unnoticed.

// File: rtl/fra_pkg.sv
package fra_pkg;
    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 32;
    localparam int LINE_WORDS = 4;
    localparam int NBUF       = 2;
    localparam int FWS_W      = 2;
    localparam int LINE_W     = WORD_W * LINE_WORDS;
    localparam int WSEL_W     = $clog2(LINE_WORDS);
    localparam int BSEL_W     = $clog2(WORD_W / 8);
    localparam int OFS_W      = WSEL_W + BSEL_W;
    localparam int TAG_W      = ADDR_W - OFS_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LINE_W-1:0] line_t;
    typedef logic [FWS_W-1:0]  ws_t;

    typedef enum logic {
        DEST_CODE = 1'b0,
        DEST_DATA = 1'b1
    } dest_e;

    typedef struct packed {
        dest_e dest;
        logic  buf_sel;
        tag_t  tag;
    } acc_t;

    typedef struct packed {
        logic  vld;
        tag_t  tag;
        line_t line;
    } lbuf_t;

    function automatic tag_t line_of(input addr_t a);
        return a[ADDR_W-1:OFS_W];
    endfunction

    function automatic logic [WSEL_W-1:0] word_of(input addr_t a);
        return a[OFS_W-1:BSEL_W];
    endfunction

    function automatic word_t pick_word(input line_t l, input logic [WSEL_W-1:0] s);
        return l[s*WORD_W +: WORD_W];
    endfunction
endpackage

// File: rtl/fra_code_bufs.sv
module fra_code_bufs
    import fra_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  tag_t  look_tag,
    input  logic  inv_en,
    input  logic  inv_sel,
    input  logic  wr_en,
    input  logic  wr_sel,
    input  tag_t  wr_tag,
    input  line_t wr_line,
    output logic  hit,
    output logic  hit_sel,
    output line_t rd_line,
    output logic  other_has_next,
    output logic [NBUF-1:0] vld,
    output tag_t  tag0,
    output tag_t  tag1
);
    lbuf_t ent [NBUF];
    logic [NBUF-1:0] hit_v;
    tag_t next_tag;
    logic other;

    always_ff @(posedge clk) begin
        for (int i = 0; i < NBUF; i++) begin
            if (rst || flush) begin
                ent[i].vld <= 1'b0;
            end else if (wr_en && int'(wr_sel) == i) begin
                ent[i].vld  <= 1'b1;
                ent[i].tag  <= wr_tag;
                ent[i].line <= wr_line;
            end else if (inv_en && int'(inv_sel) == i) begin
                ent[i].vld <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < NBUF; g++) begin : g_cmp
        assign hit_v[g] = ent[g].vld && (ent[g].tag == look_tag);
        assign vld[g]   = ent[g].vld;
    end

    assign hit            = |hit_v;
    assign hit_sel        = hit_v[1];
    assign rd_line        = ent[hit_sel].line;
    assign other          = ~hit_sel;
    assign next_tag       = tag_t'(look_tag + 1'b1);
    assign other_has_next = ent[other].vld && (ent[other].tag == next_tag);
    assign tag0           = ent[0].tag;
    assign tag1           = ent[1].tag;
endmodule

// File: rtl/fra_data_buf.sv
module fra_data_buf
    import fra_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  tag_t  look_tag,
    input  logic  inv_en,
    input  logic  wr_en,
    input  tag_t  wr_tag,
    input  line_t wr_line,
    output logic  hit,
    output line_t rd_line,
    output logic  vld,
    output tag_t  tag
);
    lbuf_t ent;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            ent.vld <= 1'b0;
        end else if (wr_en) begin
            ent.vld  <= 1'b1;
            ent.tag  <= wr_tag;
            ent.line <= wr_line;
        end else if (inv_en) begin
            ent.vld <= 1'b0;
        end
    end

    assign hit     = ent.vld && (ent.tag == look_tag);
    assign rd_line = ent.line;
    assign vld     = ent.vld;
    assign tag     = ent.tag;
endmodule

// File: rtl/fra_line_engine.sv
module fra_line_engine
    import fra_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  ws_t  fws,
    input  logic start,
    input  acc_t start_acc,
    output acc_t act,
    output acc_t cur,
    output logic active,
    output logic done,
    output logic busy,
    output logic last
);
    acc_t q;
    logic busy_q;
    ws_t  cnt_q;
    ws_t  cnt_now;

    assign active  = start | busy_q;
    assign act     = start ? start_acc : q;
    assign cnt_now = start ? '0 : cnt_q;
    // the access ends in the cycle its count reaches the wait-state setting
    assign done    = active && !flush && (cnt_now == fws);
    assign busy    = busy_q;
    assign last    = busy_q && (cnt_q == fws);
    assign cur     = q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            q      <= '0;
        end else if (active && !done) begin
            busy_q <= 1'b1;
            cnt_q  <= ws_t'(cnt_now + 1'b1);
            q      <= act;
        end else begin
            busy_q <= 1'b0;
        end
    end
endmodule

// File: rtl/flash_read_accel.sv
module flash_read_accel
    import fra_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic [1:0]   fws,
    input  logic         req_valid,
    input  logic         req_is_data,
    input  logic [31:0]  req_addr,
    output logic         rsp_ready,
    output logic [31:0]  rsp_rdata,
    output logic         fl_req,
    output logic [27:0]  fl_addr,
    input  logic [127:0] fl_rdata
);
    tag_t  req_tag;
    logic [WSEL_W-1:0] req_word;
    dest_e req_kind;
    logic  code_req, data_req;

    logic  code_hit, code_hit_sel, other_has_next;
    line_t code_line, data_line;
    logic  data_hit;
    logic [NBUF-1:0] code_vld;
    tag_t  code_tag0, code_tag1, data_tag;
    logic  data_vld;

    logic  start;
    acc_t  start_acc;
    acc_t  eng_act, eng_cur;
    logic  eng_active, eng_done, eng_busy, eng_last;
    logic  fwd;
    logic  last_buf;

    logic  unused_lsb;
    assign unused_lsb = ^req_addr[BSEL_W-1:0];

    assign req_tag  = line_of(req_addr);
    assign req_word = word_of(req_addr);
    assign req_kind = req_is_data ? DEST_DATA : DEST_CODE;
    assign code_req = req_valid && !req_is_data && !flush;
    assign data_req = req_valid &&  req_is_data && !flush;

    // access launch: code miss (may cancel a code prefetch), data miss, or sequential prefetch
    always_comb begin
        start     = 1'b0;
        start_acc = '0;
        if (code_req && !code_hit &&
            (!eng_busy || (eng_cur.dest == DEST_CODE && eng_cur.tag != req_tag && !eng_last))) begin
            start             = 1'b1;
            start_acc.dest    = DEST_CODE;
            start_acc.buf_sel = ~last_buf;
            start_acc.tag     = req_tag;
        end else if (data_req && !data_hit && !eng_busy) begin
            start             = 1'b1;
            start_acc.dest    = DEST_DATA;
            start_acc.buf_sel = 1'b0;
            start_acc.tag     = req_tag;
        end else if (code_req && code_hit && !eng_busy && !other_has_next) begin
            start             = 1'b1;
            start_acc.dest    = DEST_CODE;
            start_acc.buf_sel = ~code_hit_sel;
            start_acc.tag     = tag_t'(req_tag + 1'b1);
        end
    end

    fra_line_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .fws       (fws),
        .start     (start),
        .start_acc (start_acc),
        .act       (eng_act),
        .cur       (eng_cur),
        .active    (eng_active),
        .done      (eng_done),
        .busy      (eng_busy),
        .last      (eng_last)
    );

    fra_code_bufs u_code (
        .clk            (clk),
        .rst            (rst),
        .flush          (flush),
        .look_tag       (req_tag),
        .inv_en         (start && start_acc.dest == DEST_CODE),
        .inv_sel        (start_acc.buf_sel),
        .wr_en          (eng_done && eng_act.dest == DEST_CODE),
        .wr_sel         (eng_act.buf_sel),
        .wr_tag         (eng_act.tag),
        .wr_line        (fl_rdata),
        .hit            (code_hit),
        .hit_sel        (code_hit_sel),
        .rd_line        (code_line),
        .other_has_next (other_has_next),
        .vld            (code_vld),
        .tag0           (code_tag0),
        .tag1           (code_tag1)
    );

    fra_data_buf u_data (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .look_tag (req_tag),
        .inv_en   (start && start_acc.dest == DEST_DATA),
        .wr_en    (eng_done && eng_act.dest == DEST_DATA),
        .wr_tag   (eng_act.tag),
        .wr_line  (fl_rdata),
        .hit      (data_hit),
        .rd_line  (data_line),
        .vld      (data_vld),
        .tag      (data_tag)
    );

    // completing line goes straight to the requester when it is the one waited for
    assign fwd = eng_done && req_valid && (eng_act.dest == req_kind) && (eng_act.tag == req_tag);

    always_comb begin
        rsp_ready = fwd || (code_req && code_hit) || (data_req && data_hit);
        if (fwd)
            rsp_rdata = pick_word(fl_rdata, req_word);
        else if (req_is_data)
            rsp_rdata = pick_word(data_line, req_word);
        else
            rsp_rdata = pick_word(code_line, req_word);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_buf <= 1'b0;
        end else if (fwd && req_kind == DEST_CODE) begin
            last_buf <= eng_act.buf_sel;
        end else if (code_req && code_hit) begin
            last_buf <= code_hit_sel;
        end
    end

    assign fl_req  = eng_active;
    assign fl_addr = eng_act.tag;
endmodule

// File: rtl/fra_checker.sv
module fra_checker
    import fra_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        flush,
    input logic        req_valid,
    input logic        req_is_data,
    input logic [31:0] req_addr,
    input logic        rsp_ready,
    input logic        fl_req,
    input logic [NBUF-1:0] code_vld,
    input tag_t        code_tag0,
    input tag_t        code_tag1,
    input logic        data_vld,
    input tag_t        data_tag,
    input logic        eng_busy
);
    tag_t look;
    logic code_in_buf;
    assign look        = line_of(req_addr);
    assign code_in_buf = (code_vld[0] && code_tag0 == look) || (code_vld[1] && code_tag1 == look);

    assert_ready_has_req_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_ready |-> req_valid);

    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (code_vld == '0 && !data_vld));

    assert_tags_distinct_R8: assert property (@(posedge clk) disable iff (rst)
        (&code_vld) |-> (code_tag0 != code_tag1));

    assert_code_hit_now_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_is_data && !flush && code_in_buf) |-> rsp_ready);

    assert_data_hit_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_is_data && !flush && !eng_busy && data_vld && data_tag == look)
        |-> (rsp_ready && !fl_req));
endmodule

bind flash_read_accel fra_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush),
    .req_valid   (req_valid),
    .req_is_data (req_is_data),
    .req_addr    (req_addr),
    .rsp_ready   (rsp_ready),
    .fl_req      (fl_req),
    .code_vld    (code_vld),
    .code_tag0   (code_tag0),
    .code_tag1   (code_tag1),
    .data_vld    (data_vld),
    .data_tag    (data_tag),
    .eng_busy    (eng_busy)
);

// File: tb/tb_flash_read_accel.sv
`timescale 1ns/100ps
module tb_flash_read_accel;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         flush = 1'b0;
    logic [1:0]   fws = 2'd3;
    logic         req_valid = 1'b0;
    logic         req_is_data = 1'b0;
    logic [31:0]  req_addr = '0;
    logic         rsp_ready;
    logic [31:0]  rsp_rdata;
    logic         fl_req;
    logic [27:0]  fl_addr;
    logic [127:0] fl_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    flash_read_accel dut (
        .clk(clk), .rst(rst), .flush(flush), .fws(fws),
        .req_valid(req_valid), .req_is_data(req_is_data), .req_addr(req_addr),
        .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
        .fl_req(fl_req), .fl_addr(fl_addr), .fl_rdata(fl_rdata)
    );

    function automatic logic [31:0] model_word(input logic [31:0] a);
        return ({2'b00, a[31:2]} * 32'h0001_9E37) ^ 32'hC0DE_0000;
    endfunction

    // word k of a line sits at bits [32k+31:32k]
    function automatic logic [127:0] model_line(input logic [27:0] t);
        logic [127:0] l;
        for (int k = 0; k < 4; k++)
            l[k*32 +: 32] = model_word({t, 4'b0000} + 32'(k * 4));
        return l;
    endfunction

    // behavioural flash: the line is valid only after FWS+1 cycles of stable address
    logic [27:0] prev_addr = '0;
    logic        prev_v = 1'b0;
    int          run = 0;
    int          age;
    always @(posedge clk) begin
        if (fl_req) begin
            run       <= (prev_v && fl_addr == prev_addr) ? run + 1 : 1;
            prev_addr <= fl_addr;
            prev_v    <= 1'b1;
        end else begin
            run    <= 0;
            prev_v <= 1'b0;
        end
    end
    always_comb begin
        age      = (fl_req && prev_v && fl_addr == prev_addr) ? run : 0;
        fl_rdata = (age >= int'(fws)) ? model_line(fl_addr) : {4{32'hBAD0_BAD0}};
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // starts at posedge+1, returns at posedge+1 with req_valid low
    task automatic do_read(input logic kind, input logic [31:0] a, input int exp_cyc, input string rq);
        int cyc = 0;
        req_valid   = 1'b1;
        req_is_data = kind;
        req_addr    = a;
        forever begin
            @(negedge clk);
            cyc++;
            if (rsp_ready || cyc > 40) break;
            @(posedge clk); #1;
        end
        chk(rsp_ready == 1'b1 && rsp_rdata == model_word(a), rq, "read data", rsp_rdata, model_word(a));
        chk(cyc == exp_cyc, rq, "latency", 32'(cyc), 32'(exp_cyc));
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    typedef struct packed {
        logic        kind;
        logic [1:0]  ws;
        logic [31:0] addr;
        logic [3:0]  cyc;
        logic [3:0]  rq;
    } vec_t;

    localparam vec_t VECS [21] = '{
        '{1'b0, 2'd3, 32'h0000_0100, 4'd4, 4'd2},   // R2 R1 first code miss
        '{1'b0, 2'd3, 32'h0000_0104, 4'd1, 4'd3},   // R3 hit, R4 prefetch starts
        '{1'b0, 2'd3, 32'h0000_0108, 4'd1, 4'd3},
        '{1'b0, 2'd3, 32'h0000_010C, 4'd1, 4'd3},
        '{1'b0, 2'd3, 32'h0000_0110, 4'd1, 4'd4},   // R4 next line in one cycle
        '{1'b0, 2'd3, 32'h0000_0114, 4'd1, 4'd4},
        '{1'b0, 2'd3, 32'h0000_0118, 4'd1, 4'd4},
        '{1'b0, 2'd3, 32'h0000_011C, 4'd1, 4'd4},
        '{1'b0, 2'd3, 32'h0000_0120, 4'd1, 4'd4},
        '{1'b1, 2'd3, 32'h0000_0400, 4'd4, 4'd5},   // R5 data miss
        '{1'b1, 2'd3, 32'h0000_040C, 4'd1, 4'd5},   // R5 out of order
        '{1'b1, 2'd3, 32'h0000_0404, 4'd1, 4'd5},
        '{1'b0, 2'd3, 32'h0000_0124, 4'd1, 4'd4},   // starts prefetch of 0x130
        '{1'b1, 2'd3, 32'h0000_0800, 4'd7, 4'd6},   // R6 data waits for prefetch
        '{1'b0, 2'd3, 32'h0000_0130, 4'd1, 4'd4},
        '{1'b0, 2'd3, 32'h0000_0200, 4'd4, 4'd7},   // R7 cancels prefetch of 0x140
        '{1'b0, 2'd3, 32'h0000_0130, 4'd1, 4'd8},   // R8 previous line kept
        '{1'b0, 2'd0, 32'h0000_0600, 4'd1, 4'd11},  // R11
        '{1'b1, 2'd0, 32'h0000_0A00, 4'd1, 4'd11},  // R11
        '{1'b0, 2'd1, 32'h0000_0700, 4'd2, 4'd2},   // R2
        '{1'b1, 2'd2, 32'h0000_0B00, 4'd3, 4'd2}    // R2
    };

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 R10 reset state
        chk(rsp_ready == 1'b0, "R10", "ready in reset", 32'(rsp_ready), 32'd0);
        chk(fl_req == 1'b0, "R9", "flash idle in reset", 32'(fl_req), 32'd0);
        @(posedge clk); #1;
        rst = 1'b0;
        @(posedge clk); #1;

        for (int i = 0; i < 21; i++) begin
            if (VECS[i].ws != fws) begin
                repeat (6) @(posedge clk);
                #1;
                fws = VECS[i].ws;
            end
            do_read(VECS[i].kind, VECS[i].addr, int'(VECS[i].cyc), $sformatf("R%0d", VECS[i].rq));
        end

        // R10: no ready once the request is withdrawn
        @(negedge clk);
        chk(rsp_ready == 1'b0, "R10", "ready without request", 32'(rsp_ready), 32'd0);
        @(posedge clk); #1;

        // R9 flush
        do_read(1'b0, 32'h0000_0704, 1, "R3");
        repeat (5) @(posedge clk);
        #1;
        flush = 1'b1;
        @(posedge clk); #1;
        flush = 1'b0;
        do_read(1'b0, 32'h0000_0704, 3, "R9");
        do_read(1'b1, 32'h0000_0B04, 3, "R9");
        @(negedge clk);
        chk(rsp_ready == 1'b0, "R10", "single ready pulse", 32'(rsp_ready), 32'd0);
        @(posedge clk); #1;

        // R9 reset mid-run
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(rsp_ready == 1'b0 && fl_req == 1'b0, "R9", "quiet after reset",
            {30'd0, rsp_ready, fl_req}, 32'd0);
        @(posedge clk); #1;
        rst = 1'b0;
        do_read(1'b1, 32'h0000_0B08, 3, "R9");
        do_read(1'b0, 32'h0000_0708, 3, "R9");

        summary();
        $finish;
    end
endmodule